// File: doc/BRIEF.md
# Local Bus Hold Arbiter

This block decides who drives a shared local bus: the host bus controller or an external master. The external master raises a request that may be asynchronous to the system clock. The block synchronizes that request and tells the host to stop starting new cycles. It then waits until any host cycle in flight has finished and the host has dropped its lock indication. Only then does it turn off the host's address, data and status drivers, and one clock later it raises the acknowledge. When the request goes away, the acknowledge drops first, and one clock later the host drivers are switched back on.

While the drivers are off, two status lines (memory/IO select and code/interrupt-acknowledge) keep showing their last driven level. Two active-low lines (lock and operand acknowledge) are parked at logic one. The ready input going to the host is forced inactive. The acknowledge has no enable of its own and is always driven.

Top module: `bus_hold_arbiter`

## Requirements
- R1: The request passes through a two-flop synchronizer. If the request is raised on an idle, unlocked bus, the acknowledge rises at the fifth rising clock edge after the request went high.
- R2: The address, data and status enables fall one full clock before the acknowledge rises. During that clock the acknowledge is still low.
- R3: The acknowledge stays high as long as the request stays high. After the request drops, the acknowledge falls at the third rising edge, and the enables return high one edge after that.
- R4: While rstN is low, holdAck is 0, all three enables are 1 and hostHoldOff is 0. This holds even if reset is applied in the middle of a grant.
- R5: While the enables are low, padHeld (bit 0 memory/IO select, bit 1 code/interrupt-acknowledge) keeps the value hostHeld had at the last edge where the drivers were on. Changes on hostHeld have no effect during that time. While the drivers are on, padHeld follows hostHeld.
- R6: While the enables are low, padParked (bit 0 lock_n, bit 1 operand-acknowledge_n) reads 2'b11. While the drivers are on, it follows hostParked.
- R7: While the enables are low, hostReadyN is 1 whatever readyN does. Otherwise hostReadyN follows readyN.
- R8: While lockIn is high, the drivers are not turned off and no grant is given, and hostHoldOff stays low so that the locked sequence can go on.
- R9: If a host cycle is in progress (cycleActive high), the drivers are turned off only at the edge after cycleActive has gone low, which happens once readyN has ended the cycle.
- R10: hostHoldOff goes high at the edge after the synchronized request is seen. It stays high until the drivers are re-enabled, except while lockIn holds it low (R8).
- R11: If the request is withdrawn before the drivers are turned off, the block returns to host ownership without ever raising the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| holdReq | input | 1 | Bus request from the external master, active high, asynchronous |
| holdAck | output | 1 | Bus grant to the external master, active high, always driven |
| cycleActive | input | 1 | Host has a bus cycle in progress |
| lockIn | input | 1 | Host is running a locked sequence, active high |
| readyN | input | 1 | Active-low ready from the bus |
| hostReadyN | output | 1 | Ready passed on to the host, forced high while the drivers are off |
| hostHoldOff | output | 1 | Tells the host not to start new bus cycles |
| hostHeld | input | HELD_W | Host status lines that hold their level while floated |
| hostParked | input | PARK_W | Host active-low lines that park at one while floated |
| addrOe | output | 1 | Address driver enable |
| dataOe | output | 1 | Data driver enable |
| statusOe | output | 1 | Status driver enable |
| padHeld | output | HELD_W | Value presented on the held status pins |
| padParked | output | PARK_W | Value presented on the parked active-low pins |

## Verification
The hardest situation to reach is a request that is already synchronized while the host is still busy: a bus cycle stretched by a high readyN, or a lock held over several clocks. Both have to last across the synchronizer latency. The stimulus table raises the request together with cycleActive or lockIn and keeps them high for several rows before it ends the cycle or drops the lock. It also withdraws one request while the bus is still draining, to cover the path back to host ownership without a grant. A directed test then applies reset in the middle of a grant.

// File: rtl/bha_pkg.sv
package bha_pkg;

  typedef enum logic [2:0] {
    ST_OWN     = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_FLOAT   = 3'd2,
    ST_GRANT   = 3'd3,
    ST_RELEASE = 3'd4
  } arbState_t;

  typedef struct packed {
    logic driveEn;
    logic ackOn;
    logic holdOff;
  } arbStrobe_t;

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[gi] <= 1'b0;
          else       chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/bha_ctrl.sv
module bha_ctrl
  import bha_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSync,
  input  logic       cycleActive,
  input  logic       lockIn,
  output arbStrobe_t strobe
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OWN:     if (reqSync) stateNext = ST_DRAIN;
      ST_DRAIN: begin
        if (!reqSync)                    stateNext = ST_OWN;
        else if (!cycleActive && !lockIn) stateNext = ST_FLOAT;
      end
      ST_FLOAT:   stateNext = ST_GRANT;
      ST_GRANT:   if (!reqSync) stateNext = ST_RELEASE;
      ST_RELEASE: stateNext = ST_OWN;
      default:    stateNext = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OWN;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.driveEn = (state == ST_OWN) || (state == ST_DRAIN);
    strobe.ackOn   = (state == ST_GRANT);
    strobe.holdOff = (state != ST_OWN) && !((state == ST_DRAIN) && lockIn);
  end

  assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && lockIn) |=> (state != ST_FLOAT));

  assert_cycle_waits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && cycleActive) |=> (state != ST_FLOAT));

  assert_withdraw_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !reqSync) |=> (state == ST_OWN));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackOn && !reqSync) |=> !strobe.ackOn);

endmodule

// File: rtl/bha_datapath.sv
module bha_datapath
  import bha_pkg::*;
#(
  parameter int HELD_W = 2,
  parameter int PARK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic              readyN,
  input  logic [HELD_W-1:0] hostHeld,
  input  logic [PARK_W-1:0] hostParked,
  output logic              holdAck,
  output logic              hostHoldOff,
  output logic              hostReadyN,
  output logic              addrOe,
  output logic              dataOe,
  output logic              statusOe,
  output logic [HELD_W-1:0] padHeld,
  output logic [PARK_W-1:0] padParked
);

  localparam logic [PARK_W-1:0] PARK_IDLE = '1;

  logic [HELD_W-1:0] heldLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               heldLast <= '0;
    else if (strobe.driveEn) heldLast <= hostHeld;
  end

  assign addrOe      = strobe.driveEn;
  assign dataOe      = strobe.driveEn;
  assign statusOe    = strobe.driveEn;
  assign holdAck     = strobe.ackOn;
  assign hostHoldOff = strobe.holdOff;
  assign hostReadyN  = strobe.driveEn ? readyN : 1'b1;
  assign padHeld     = strobe.driveEn ? hostHeld : heldLast;
  assign padParked   = strobe.driveEn ? hostParked : PARK_IDLE;

  assert_float_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> $past(!addrOe));

  assert_ready_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> hostReadyN);

  assert_parked_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOe) |-> (padParked == PARK_IDLE));

  assert_held_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!statusOe && $past(!statusOe)) |-> $stable(padHeld));

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HELD_W      = 2,
  parameter int PARK_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdReq,
  output logic              holdAck,
  input  logic              cycleActive,
  input  logic              lockIn,
  input  logic              readyN,
  output logic              hostReadyN,
  output logic              hostHoldOff,
  input  logic [HELD_W-1:0] hostHeld,
  input  logic [PARK_W-1:0] hostParked,
  output logic              addrOe,
  output logic              dataOe,
  output logic              statusOe,
  output logic [HELD_W-1:0] padHeld,
  output logic [PARK_W-1:0] padParked
);

  logic       reqSync;
  arbStrobe_t strobe;

  bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(holdReq), .syncOut(reqSync)
  );

  bha_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqSync(reqSync),
    .cycleActive(cycleActive), .lockIn(lockIn), .strobe(strobe)
  );

  bha_datapath #(.HELD_W(HELD_W), .PARK_W(PARK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readyN(readyN),
    .hostHeld(hostHeld), .hostParked(hostParked),
    .holdAck(holdAck), .hostHoldOff(hostHoldOff), .hostReadyN(hostReadyN),
    .addrOe(addrOe), .dataOe(dataOe), .statusOe(statusOe),
    .padHeld(padHeld), .padParked(padParked)
  );

endmodule

// File: tb/bus_hold_arbiter_tb.sv
`timescale 1ns/1ps
module bus_hold_arbiter_tb;

  logic clk = 1'b0;
  logic rstN, holdReq, cycleActive, lockIn, readyN;
  logic [1:0] hostHeld, hostParked;
  logic holdAck, hostReadyN, hostHoldOff, addrOe, dataOe, statusOe;
  logic [1:0] padHeld, padParked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bus_hold_arbiter u_dut (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .holdAck(holdAck),
    .cycleActive(cycleActive), .lockIn(lockIn), .readyN(readyN),
    .hostReadyN(hostReadyN), .hostHoldOff(hostHoldOff),
    .hostHeld(hostHeld), .hostParked(hostParked),
    .addrOe(addrOe), .dataOe(dataOe), .statusOe(statusOe),
    .padHeld(padHeld), .padParked(padParked)
  );

  // Row: inputs {req,cyc,lock,rdyN,held[1:0],park[1:0]} | expected {ack,oe,holdOff,rdyOutN,held[1:0],park[1:0]}
  localparam logic [15:0] VEC [36] = '{
    16'b0_0_0_1_10_00__0_1_0_1_10_00, // 0 idle
    16'b1_0_0_1_10_00__0_1_0_1_10_00, // 1 R1 sync stage 1
    16'b1_0_0_1_10_00__0_1_0_1_10_00, // 2 R1 sync stage 2
    16'b1_0_0_1_10_00__0_1_1_1_10_00, // 3 R10 drain
    16'b1_0_0_1_10_00__0_0_1_1_10_11, // 4 R2 float, ack low
    16'b1_0_0_1_10_00__1_0_1_1_10_11, // 5 R1 ack on fifth edge
    16'b1_0_0_0_01_00__1_0_1_1_10_11, // 6 R5 R7 held kept, ready ignored
    16'b0_0_0_1_01_00__1_0_1_1_10_11, // 7 R3
    16'b0_0_0_1_01_00__1_0_1_1_10_11, // 8 R3
    16'b0_0_0_1_01_00__0_0_1_1_10_11, // 9 R3 ack falls third edge
    16'b0_0_0_1_01_00__0_1_0_1_01_00, // 10 R3 drivers back
    16'b1_0_1_1_01_00__0_1_0_1_01_00, // 11 R8
    16'b1_0_1_1_01_00__0_1_0_1_01_00, // 12 R8
    16'b1_0_1_1_01_00__0_1_0_1_01_00, // 13 R8 drain, lock keeps holdOff low
    16'b1_0_1_1_01_00__0_1_0_1_01_00, // 14 R8 still blocked
    16'b1_0_0_1_01_00__0_0_1_1_01_11, // 15 R8 lock dropped, float
    16'b0_0_0_1_11_00__1_0_1_1_01_11, // 16 R5
    16'b0_0_0_1_11_00__1_0_1_1_01_11, // 17 R5
    16'b0_0_0_1_11_00__0_0_1_1_01_11, // 18 R6
    16'b0_0_0_1_11_01__0_1_0_1_11_01, // 19 R6 pass-through
    16'b1_1_0_1_11_01__0_1_0_1_11_01, // 20 R9
    16'b1_1_0_1_11_01__0_1_0_1_11_01, // 21 R9
    16'b1_1_0_1_11_01__0_1_1_1_11_01, // 22 R9 drain, cycle open
    16'b1_1_0_1_11_01__0_1_1_1_11_01, // 23 R9
    16'b1_1_0_0_11_01__0_1_1_0_11_01, // 24 R9 R7 ready ends cycle
    16'b1_0_0_1_11_01__0_0_1_1_11_11, // 25 R9 float after cycle end
    16'b0_0_0_1_11_01__1_0_1_1_11_11, // 26
    16'b0_0_0_1_11_01__1_0_1_1_11_11, // 27
    16'b0_0_0_1_11_01__0_0_1_1_11_11, // 28
    16'b0_0_0_1_11_01__0_1_0_1_11_01, // 29
    16'b1_1_0_1_11_01__0_1_0_1_11_01, // 30 R11
    16'b1_1_0_1_11_01__0_1_0_1_11_01, // 31 R11
    16'b1_1_0_1_11_01__0_1_1_1_11_01, // 32 R11 drain
    16'b0_1_0_1_11_01__0_1_1_1_11_01, // 33 R11 withdrawn
    16'b0_1_0_1_11_01__0_1_1_1_11_01, // 34 R11
    16'b0_1_0_1_11_01__0_1_0_1_11_01  // 35 R11 back to host, no ack
  };

  task automatic check(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check("R4", {tag, " ack"},     {2'b0, holdAck}, 3'b000);
    check("R4", {tag, " enables"}, {addrOe, dataOe, statusOe}, 3'b111);
    check("R4", {tag, " holdOff"}, {2'b0, hostHoldOff}, 3'b000);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    rstN = 1'b0; holdReq = 1'b0; cycleActive = 1'b0; lockIn = 1'b0;
    readyN = 1'b1; hostHeld = 2'b10; hostParked = 2'b00;
    repeat (3) @(posedge clk);
    #2 check_reset_state("initial reset");
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 36; i++) begin
      logic [15:0] row;
      row = VEC[i];
      @(negedge clk);
      holdReq = row[15]; cycleActive = row[14]; lockIn = row[13];
      readyN = row[12]; hostHeld = row[11:10]; hostParked = row[9:8];
      @(posedge clk);
      #2;
      check("R1", $sformatf("row %0d ack", i), {2'b0, holdAck}, {2'b0, row[7]});
      check("R2", $sformatf("row %0d enables", i), {addrOe, dataOe, statusOe}, {3{row[6]}});
      check("R10", $sformatf("row %0d holdOff", i), {2'b0, hostHoldOff}, {2'b0, row[5]});
      check("R7", $sformatf("row %0d hostReadyN", i), {2'b0, hostReadyN}, {2'b0, row[4]});
      check("R5", $sformatf("row %0d padHeld", i), {1'b0, padHeld}, {1'b0, row[3:2]});
      check("R6", $sformatf("row %0d padParked", i), {1'b0, padParked}, {1'b0, row[1:0]});
    end

    // R4: reset in the middle of a grant
    @(negedge clk);
    holdReq = 1'b1; cycleActive = 1'b0; lockIn = 1'b0;
    repeat (5) @(posedge clk);
    #2 check("R1", "directed grant before reset", {2'b0, holdAck}, 3'b001);
    @(negedge clk) rstN = 1'b0;
    #1 check_reset_state("reset during grant");
    @(negedge clk) holdReq = 1'b0;
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    #2 check("R4", "no ack after reset with request gone", {2'b0, holdAck}, 3'b000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule